// File: doc/BRIEF.md
# Time-Slotted Serial Output Formatter

This block turns a set of parallel sample words into a framed bit stream. The stream goes out on one serial data line, and a companion sync line marks where slots begin or end. A strobe tells the block that fresh samples are ready. On that strobe it copies every source word into a holding bank. It then waits a programmable number of clocks and walks through seven slots in a fixed order. Each slot sends the upper bits of a chosen source, most significant bit first.

Each slot has its own content selector, width code and sync enable. One setting places the sync pulse for all slots: one clock before the first bit, on the first bit, or one clock after the last bit. A routing enable gates both lines to their inactive levels. This lets the outputs of several synchronous formatters be OR-ed onto one shared line, each delayed so that its frame falls into its own time window.

Top module: `slot_serializer`

## Requirements
- R1: A frame visits slots 0 to 6 in rising order. An enabled slot sends exactly its width in bits, most significant bit first. Width codes on `slot_wid` (4 bits per slot, slot k at bits 4k+3..4k) are: 1=4, 2=6, 3=8, 4=10, 5=12, 6=16, 7=20, 8=24, 9=32 bits. Code 0 and codes 10..15 disable the slot.
- R2: Source codes on `slot_src` (3 bits per slot, slot k at bits 3k+2..3k) are: 0=all zeros, 1=I1, 2=Q1, 3=I2, 4=Q2, 5=magnitude, 6=phase/phase rate, 7=gain. A slot narrower than the sample sends the top bits of the 24-bit sample, truncated.
- R3: A 32-bit slot sends all 24 sample bits followed by 8 zero bits.
- R4: A disabled slot fills one clock with a 0 data bit if an enabled slot comes later in the frame. It fills no clock if none does. A frame with no enabled slot sends nothing.
- R5: With delay D on `start_dly` (0..4095) and on-bit sync placement, the first data bit is on `sdata` in the cycle that starts D+2 clock edges after the edge that samples `strobe`. Bits then follow back to back.
- R6: `sync_pos` selects the sync placement: 0 = one clock before the slot's first bit, 1 (or 3) = on the first bit, 2 = one clock after the last bit. In mode 0 the data is sent one clock later than in mode 1. Only slots whose `slot_sync_en` bit is set produce a one-clock sync pulse.
- R7: `sync_inv`=1 makes the sync line active low, with an idle level of 1.
- R8: While `route_en` is 0, `sdata` stays 0 and `sync` stays at its inactive level. Sequencing and `busy` are unaffected.
- R9: The source words are captured on the accepted strobe. Changes on the sample inputs during a frame do not alter that frame.
- R10: A strobe that arrives while `busy` is high is ignored and sets the `overrun` flag. That flag stays set until reset.
- R11: `busy` is high from the cycle after the accepting edge through the cycle that shows the last frame element. When the block is idle, `sdata` is 0 and `sync` is at its inactive level.
- R12: After reset, `busy`, `overrun` and `sdata` are 0 and `sync` is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | New samples ready |
| smp_i1 | input | SAMPLE_W | In-phase sample, path 1 |
| smp_q1 | input | SAMPLE_W | Quadrature sample, path 1 |
| smp_i2 | input | SAMPLE_W | In-phase sample, path 2 |
| smp_q2 | input | SAMPLE_W | Quadrature sample, path 2 |
| smp_mag | input | SAMPLE_W | Magnitude |
| smp_phs | input | SAMPLE_W | Phase or phase rate |
| smp_gain | input | SAMPLE_W | Gain word |
| slot_src | input | NSLOT*3 | Per-slot source codes |
| slot_wid | input | NSLOT*4 | Per-slot width codes |
| slot_sync_en | input | NSLOT | Per-slot sync enable |
| sync_pos | input | 2 | Sync placement mode |
| sync_inv | input | 1 | Sync polarity (1 = active low) |
| start_dly | input | DLY_W | Strobe-to-output delay in clocks |
| route_en | input | 1 | Output routing gate |
| sdata | output | 1 | Serial data |
| sync | output | 1 | Serial sync |
| busy | output | 1 | Frame in progress |
| overrun | output | 1 | Sticky strobe-while-busy flag |

## Verification
The embedded properties assume that the slot widths, sync placement and delay stay constant while `busy` is high. A width change in the middle of a slot could break the bit-counter bound, and a mode change could shift the tail length. The stimulus changes configuration only between frames, after `busy` has fallen. It changes the sample inputs and re-pulses the strobe during a frame only on purpose, to exercise the capture and overrun rules. `sync_inv` is held steady across each frame, because the gating property compares the sync level with its value one cycle earlier.

// File: rtl/slot_ser_pkg.sv
package slot_ser_pkg;

  localparam int SRC_W = 3;
  localparam int WID_W = 4;
  localparam int LEN_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_TAIL = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    SP_EARLY = 2'd0,
    SP_ALIGN = 2'd1,
    SP_LATE  = 2'd2,
    SP_RSVD  = 2'd3
  } sync_pos_e;

  // one element of the internal stream, before sync placement
  typedef struct packed {
    logic valid;
    logic dbit;
    logic first;
    logic last;
  } tick_t;

  // width code to slot length in clocks, 0 means disabled
  function automatic logic [LEN_W-1:0] slot_len(input logic [WID_W-1:0] code);
    logic [LEN_W-1:0] n;
    case (code)
      4'd1:    n = LEN_W'(4);
      4'd2:    n = LEN_W'(6);
      4'd3:    n = LEN_W'(8);
      4'd4:    n = LEN_W'(10);
      4'd5:    n = LEN_W'(12);
      4'd6:    n = LEN_W'(16);
      4'd7:    n = LEN_W'(20);
      4'd8:    n = LEN_W'(24);
      4'd9:    n = LEN_W'(32);
      default: n = '0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/slot_src_mux.sv
module slot_src_mux
  import slot_ser_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              load,
  input  logic [(1<<SRC_W)*SAMPLE_W-1:0]    src_flat,
  input  logic [SRC_W-1:0]                  sel,
  input  logic [LEN_W-1:0]                  bit_idx,
  output logic                              dbit
);

  localparam int NSRC = 1 << SRC_W;

  logic [SAMPLE_W-1:0] hold [NSRC];
  logic [SAMPLE_W-1:0] cur;
  logic [SAMPLE_W-1:0] shifted;

  // holding bank: every source copied on the accepted strobe
  for (genvar s = 0; s < NSRC; s++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst) begin
        hold[s] <= '0;
      end else if (load) begin
        hold[s] <= src_flat[s*SAMPLE_W +: SAMPLE_W];
      end
    end
  end

  always_comb begin
    cur     = hold[sel];
    shifted = cur << bit_idx;
    // bits past the sample width are padding zeros
    dbit    = (bit_idx < LEN_W'(SAMPLE_W)) ? shifted[SAMPLE_W-1] : 1'b0;
  end

endmodule

// File: rtl/slot_frame_seq.sv
module slot_frame_seq
  import slot_ser_pkg::*;
#(
  parameter int NSLOT = 7,
  parameter int DLY_W = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      strobe,
  input  logic [NSLOT*WID_W-1:0]    slot_wid,
  input  logic [NSLOT-1:0]          slot_sync_en,
  input  logic [1:0]                sync_pos,
  input  logic [DLY_W-1:0]          start_dly,
  output logic                      load,
  output logic [$clog2(NSLOT)-1:0]  cur_slot,
  output logic [LEN_W-1:0]          cur_bit,
  output logic                      run_on,
  output logic                      slot_on,
  output logic                      sync_first,
  output logic                      sync_last,
  output logic                      busy,
  output logic                      overrun
);

  localparam int SLOT_W = $clog2(NSLOT);

  seq_state_e        state_q;
  logic [DLY_W-1:0]  dcnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic [LEN_W-1:0]  bit_q;
  logic              tail_q;

  logic [LEN_W-1:0]  len_a [NSLOT];
  logic [NSLOT-1:0]  act;
  logic [NSLOT-1:0]  more;
  logic [LEN_W-1:0]  cur_len;
  logic              slot_end;
  logic              tail_len;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign len_a[k] = slot_len(slot_wid[k*WID_W +: WID_W]);
    assign act[k]   = (len_a[k] != '0);
    if (k == NSLOT-1) begin : g_last
      assign more[k] = 1'b0;
    end else begin : g_mid
      assign more[k] = |act[NSLOT-1:k+1];
    end
  end

  always_comb begin
    // a disabled slot in the middle of a frame is a one-clock placeholder
    cur_len  = act[slot_q] ? len_a[slot_q] : LEN_W'(1);
    slot_end = (bit_q == cur_len - 1'b1);
    tail_len = (sync_pos == SP_EARLY) || (sync_pos == SP_LATE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
      slot_q  <= '0;
      bit_q   <= '0;
      tail_q  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (strobe && (state_q != ST_IDLE)) begin
        overrun <= 1'b1;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (strobe) begin
            state_q <= ST_WAIT;
            dcnt_q  <= start_dly;
          end
        end
        ST_WAIT: begin
          if (dcnt_q == '0) begin
            slot_q  <= '0;
            bit_q   <= '0;
            tail_q  <= tail_len;
            state_q <= (|act) ? ST_RUN : ST_TAIL;
          end else begin
            dcnt_q <= dcnt_q - 1'b1;
          end
        end
        ST_RUN: begin
          if (slot_end) begin
            bit_q <= '0;
            if (more[slot_q]) begin
              slot_q <= slot_q + 1'b1;
            end else begin
              state_q <= ST_TAIL;
              tail_q  <= tail_len;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tail_q) begin
            tail_q <= 1'b0;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    load       = (state_q == ST_IDLE) && strobe;
    busy       = (state_q != ST_IDLE);
    run_on     = (state_q == ST_RUN);
    slot_on    = run_on && act[slot_q];
    sync_first = slot_on && slot_sync_en[slot_q] && (bit_q == '0);
    sync_last  = slot_on && slot_sync_en[slot_q] && slot_end;
    cur_slot   = slot_q;
    cur_bit    = bit_q;
  end

  // R5: the delay counter keeps the frame waiting while it is non-zero
  p_wait_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && dcnt_q != '0) |=> (state_q == ST_WAIT));

  // R10: overrun never clears outside reset
  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R10: a strobe during a frame must raise overrun
  p_busy_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && strobe) |=> overrun);

  // R1: the bit counter stays inside the current slot
  p_bit_bound_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> (bit_q < cur_len));

  // R1, R4: slots advance by one at a time, never back
  p_slot_step_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && $past(state_q) == ST_RUN) |->
      (slot_q == $past(slot_q) || slot_q == $past(slot_q) + 1'b1));

endmodule

// File: rtl/slot_out_stage.sv
module slot_out_stage
  import slot_ser_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  tick_t       tk,
  input  logic [1:0]  sync_pos,
  input  logic        sync_inv,
  input  logic        route_en,
  output logic        sdata,
  output logic        sync
);

  logic dly_v;
  logic dly_d;
  logic dly_last;
  logic raw_d;
  logic raw_s;

  // early: data lags sync by a clock; late: sync lags the last bit by a clock
  always_comb begin
    unique case (sync_pos)
      SP_EARLY: begin raw_d = dly_d;   raw_s = tk.first; end
      SP_LATE:  begin raw_d = tk.dbit; raw_s = dly_last; end
      default:  begin raw_d = tk.dbit; raw_s = tk.first; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_v    <= 1'b0;
      dly_d    <= 1'b0;
      dly_last <= 1'b0;
      sdata    <= 1'b0;
      sync     <= sync_inv;
    end else begin
      dly_v    <= tk.valid;
      dly_d    <= tk.valid & tk.dbit;
      dly_last <= tk.valid & tk.last;
      sdata    <= route_en & raw_d;
      sync     <= sync_inv ^ (route_en & raw_s);
    end
  end

  // R8: a closed routing gate leaves both lines quiet
  p_mask_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(route_en) |-> (!sdata && (sync == $past(sync_inv))));

  // R11: no stream element now or a clock ago means a quiet data line
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(tk.valid) && !$past(dly_v)) |-> !sdata);

endmodule

// File: rtl/slot_serializer.sv
module slot_serializer
  import slot_ser_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int NSLOT    = 7,
  parameter int DLY_W    = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    strobe,
  input  logic [SAMPLE_W-1:0]     smp_i1,
  input  logic [SAMPLE_W-1:0]     smp_q1,
  input  logic [SAMPLE_W-1:0]     smp_i2,
  input  logic [SAMPLE_W-1:0]     smp_q2,
  input  logic [SAMPLE_W-1:0]     smp_mag,
  input  logic [SAMPLE_W-1:0]     smp_phs,
  input  logic [SAMPLE_W-1:0]     smp_gain,
  input  logic [NSLOT*SRC_W-1:0]  slot_src,
  input  logic [NSLOT*WID_W-1:0]  slot_wid,
  input  logic [NSLOT-1:0]        slot_sync_en,
  input  logic [1:0]              sync_pos,
  input  logic                    sync_inv,
  input  logic [DLY_W-1:0]        start_dly,
  input  logic                    route_en,
  output logic                    sdata,
  output logic                    sync,
  output logic                    busy,
  output logic                    overrun
);

  localparam int SLOT_W = $clog2(NSLOT);
  localparam int NSRC   = 1 << SRC_W;

  logic [NSRC*SAMPLE_W-1:0] src_flat;
  logic [SRC_W-1:0]         src_a [NSLOT];
  logic                     load;
  logic [SLOT_W-1:0]        cur_slot;
  logic [LEN_W-1:0]         cur_bit;
  logic                     run_on;
  logic                     slot_on;
  logic                     sync_first;
  logic                     sync_last;
  logic                     mux_bit;
  tick_t                    tk;

  // source index 0 is the constant-zero source
  assign src_flat = {smp_gain, smp_phs, smp_mag, smp_q2, smp_i2, smp_q1, smp_i1,
                     {SAMPLE_W{1'b0}}};

  for (genvar k = 0; k < NSLOT; k++) begin : g_src
    assign src_a[k] = slot_src[k*SRC_W +: SRC_W];
  end

  slot_frame_seq #(
    .NSLOT (NSLOT),
    .DLY_W (DLY_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .slot_wid     (slot_wid),
    .slot_sync_en (slot_sync_en),
    .sync_pos     (sync_pos),
    .start_dly    (start_dly),
    .load         (load),
    .cur_slot     (cur_slot),
    .cur_bit      (cur_bit),
    .run_on       (run_on),
    .slot_on      (slot_on),
    .sync_first   (sync_first),
    .sync_last    (sync_last),
    .busy         (busy),
    .overrun      (overrun)
  );

  slot_src_mux #(
    .SAMPLE_W (SAMPLE_W)
  ) u_mux (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .src_flat (src_flat),
    .sel      (src_a[cur_slot]),
    .bit_idx  (cur_bit),
    .dbit     (mux_bit)
  );

  always_comb begin
    tk.valid = run_on;
    tk.dbit  = slot_on & mux_bit;
    tk.first = sync_first;
    tk.last  = sync_last;
  end

  slot_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .tk       (tk),
    .sync_pos (sync_pos),
    .sync_inv (sync_inv),
    .route_en (route_en),
    .sdata    (sdata),
    .sync     (sync)
  );

endmodule

// File: tb/slot_serializer_bench.sv
module slot_serializer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAXC       = 4600;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b0;
  logic [23:0] v_i1, v_q1, v_i2, v_q2, v_mag, v_phs, v_gain;
  logic [20:0] b_src;
  logic [27:0] b_wid;
  logic [6:0]  b_sen;
  logic [1:0]  b_pos;
  logic        b_inv;
  logic [11:0] b_dly;
  logic        b_route;
  logic        sdata, sync, busy, overrun;

  int checks   = 0;
  int failures = 0;

  bit          exp_d [MAXC];
  bit          exp_s [MAXC];
  bit          tk_d  [256];
  bit          tk_f  [256];
  bit          tk_l  [256];
  logic [23:0] snap  [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_serializer u_slot_serializer (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .smp_i1       (v_i1),
    .smp_q1       (v_q1),
    .smp_i2       (v_i2),
    .smp_q2       (v_q2),
    .smp_mag      (v_mag),
    .smp_phs      (v_phs),
    .smp_gain     (v_gain),
    .slot_src     (b_src),
    .slot_wid     (b_wid),
    .slot_sync_en (b_sen),
    .sync_pos     (b_pos),
    .sync_inv     (b_inv),
    .start_dly    (b_dly),
    .route_en     (b_route),
    .sdata        (sdata),
    .sync         (sync),
    .busy         (busy),
    .overrun      (overrun)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic int mdl_len(input logic [3:0] c);
    case (c)
      4'd1: return 4;
      4'd2: return 6;
      4'd3: return 8;
      4'd4: return 10;
      4'd5: return 12;
      4'd6: return 16;
      4'd7: return 20;
      4'd8: return 24;
      4'd9: return 32;
      default: return 0;
    endcase
  endfunction

  task automatic clear_cfg();
    b_src = '0; b_wid = '0; b_sen = '0; b_pos = 2'd1;
    b_inv = 1'b0; b_dly = '0; b_route = 1'b1;
  endtask

  task automatic set_slot(input int k, input logic [2:0] src, input logic [3:0] wc,
                          input bit sen);
    b_src[3*k +: 3] = src;
    b_wid[4*k +: 4] = wc;
    b_sen[k]        = sen;
  endtask

  task automatic load_samples();
    v_i1 = 24'hA5C396; v_q1 = 24'h3C5A0F; v_i2 = 24'hF0E1D2; v_q2 = 24'h0F1E2D;
    v_mag = 24'h813579; v_phs = 24'h6B2E44; v_gain = 24'hC7D8E9;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // reference stream: one entry per clock of the frame body
  task automatic build_ticks(output int n);
    n = 0;
    for (int s = 0; s < 7; s++) begin
      int w;
      bit later;
      w = mdl_len(b_wid[4*s +: 4]);
      later = 1'b0;
      for (int j = s + 1; j < 7; j++) if (mdl_len(b_wid[4*j +: 4]) != 0) later = 1'b1;
      if (w != 0) begin
        for (int b = 0; b < w; b++) begin
          tk_d[n] = (b < 24) ? snap[b_src[3*s +: 3]][23-b] : 1'b0;
          tk_f[n] = b_sen[s] && (b == 0);
          tk_l[n] = b_sen[s] && (b == w - 1);
          n++;
        end
      end else if (later) begin
        tk_d[n] = 1'b0; tk_f[n] = 1'b0; tk_l[n] = 1'b0;
        n++;
      end
    end
  endtask

  task automatic run_frame(input string tag, input int poke_at, input int restrobe_at);
    int n, x, lastb, span, dly;
    bit bad_d, bad_s, bad_b;
    snap[0] = '0; snap[1] = v_i1; snap[2] = v_q1; snap[3] = v_i2;
    snap[4] = v_q2; snap[5] = v_mag; snap[6] = v_phs; snap[7] = v_gain;
    build_ticks(n);
    dly   = int'(b_dly);
    x     = (b_pos == 2'd0 || b_pos == 2'd2) ? 1 : 0;
    lastb = dly + n + 1 + x;
    span  = lastb + 4;
    for (int k = 0; k <= span; k++) begin exp_d[k] = 1'b0; exp_s[k] = 1'b0; end
    for (int t = 0; t < n; t++) begin
      int base;
      base = dly + 2 + t;
      case (b_pos)
        2'd0: begin exp_d[base+1] = tk_d[t]; if (tk_f[t]) exp_s[base] = 1'b1; end
        2'd2: begin exp_d[base] = tk_d[t]; if (tk_l[t]) exp_s[base+1] = 1'b1; end
        default: begin exp_d[base] = tk_d[t]; if (tk_f[t]) exp_s[base] = 1'b1; end
      endcase
    end
    bad_d = 1'b0; bad_s = 1'b0; bad_b = 1'b0;
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    for (int k = 0; k <= span; k++) begin
      bit ed, es, eb;
      if (k > 0) @(negedge clk);
      strobe = (k == restrobe_at);
      if (k == poke_at) begin
        v_i1 = ~v_i1; v_q1 = ~v_q1; v_i2 = ~v_i2; v_q2 = ~v_q2;
        v_mag = ~v_mag; v_phs = ~v_phs; v_gain = ~v_gain;
      end
      ed = b_route & exp_d[k];
      es = b_inv ^ (b_route & exp_s[k]);
      eb = (k <= lastb);
      if (sdata !== ed && !bad_d) begin
        bad_d = 1'b1;
        $display("FAIL %s sdata at cycle %0d actual=%b expected=%b", tag, k, sdata, ed);
      end
      if (sync !== es && !bad_s) begin
        bad_s = 1'b1;
        $display("FAIL %s sync at cycle %0d actual=%b expected=%b", tag, k, sync, es);
      end
      if (busy !== eb && !bad_b) begin
        bad_b = 1'b1;
        $display("FAIL %s busy (R11) at cycle %0d actual=%b expected=%b", tag, k, busy, eb);
      end
    end
    strobe = 1'b0;
    checks   += 3;
    failures += int'(bad_d) + int'(bad_s) + int'(bad_b);
  endtask

  // R12: state right after reset
  task automatic t_reset();
    chk("R12", "sdata", 32'(sdata), 32'd0);
    chk("R12", "sync", 32'(sync), 32'd0);
    chk("R12", "busy", 32'(busy), 32'd0);
    chk("R12", "overrun", 32'(overrun), 32'd0);
  endtask

  // R1: every width below 24 in slot order
  task automatic t_widths();
    clear_cfg();
    for (int k = 0; k < 7; k++) set_slot(k, 3'(k + 1), 4'(k + 1), 1'b1);
    run_frame("R1", -1, -1);
  endtask

  // R2: each source code, zero source included
  task automatic t_sources();
    clear_cfg();
    set_slot(0, 3'd0, 4'd3, 1'b0);
    for (int k = 1; k < 7; k++) set_slot(k, 3'(8 - k), 4'd3, 1'b0);
    run_frame("R2", -1, -1);
    clear_cfg();
    set_slot(0, 3'd1, 4'd5, 1'b1);
    set_slot(1, 3'd0, 4'd2, 1'b0);
    set_slot(2, 3'd7, 4'd1, 1'b1);
    run_frame("R2", -1, -1);
  endtask

  // R3: 32-bit slots carry 24 data bits then zero padding
  task automatic t_wide();
    clear_cfg();
    set_slot(0, 3'd1, 4'd9, 1'b1);
    set_slot(1, 3'd2, 4'd8, 1'b1);
    set_slot(2, 3'd7, 4'd9, 1'b1);
    run_frame("R3", -1, -1);
  endtask

  // R4: placeholders before enabled slots, nothing after the last one
  task automatic t_disabled();
    clear_cfg();
    b_dly = 12'd2;
    set_slot(1, 3'd5, 4'd1, 1'b1);
    set_slot(3, 3'd3, 4'd2, 1'b1);
    set_slot(5, 3'd4, 4'd12, 1'b1);
    run_frame("R4", -1, -1);
    clear_cfg();
    b_pos = 2'd2;
    b_sen = 7'h7F;
    run_frame("R4", -1, -1);
  endtask

  // R5: short and maximum strobe-to-output delay
  task automatic t_delay();
    clear_cfg();
    b_dly = 12'd5;
    set_slot(0, 3'd6, 4'd3, 1'b1);
    run_frame("R5", -1, -1);
    clear_cfg();
    b_dly = 12'd4095;
    set_slot(2, 3'd1, 4'd1, 1'b1);
    run_frame("R5", -1, -1);
  endtask

  // R6: all three sync placements with a subset of enables
  task automatic t_sync_pos();
    for (int p = 0; p < 4; p++) begin
      clear_cfg();
      b_pos = 2'(p);
      set_slot(0, 3'd1, 4'd1, 1'b1);
      set_slot(2, 3'd2, 4'd2, 1'b1);
      set_slot(3, 3'd3, 4'd3, 1'b0);
      set_slot(6, 3'd4, 4'd1, 1'b1);
      run_frame("R6", -1, -1);
    end
  endtask

  // R7: active-low sync, including idle level
  task automatic t_polarity();
    clear_cfg();
    b_inv = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7", "idle sync", 32'(sync), 32'd1);
    b_pos = 2'd0;
    set_slot(0, 3'd7, 4'd2, 1'b1);
    set_slot(1, 3'd5, 4'd1, 1'b1);
    run_frame("R7", -1, -1);
    b_inv = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // R8: closed routing gate, frame still sequenced
  task automatic t_mask();
    clear_cfg();
    b_route = 1'b0;
    b_inv   = 1'b1;
    set_slot(0, 3'd1, 4'd9, 1'b1);
    set_slot(1, 3'd2, 4'd3, 1'b1);
    run_frame("R8", -1, -1);
    clear_cfg();
    repeat (2) @(negedge clk);
  endtask

  // R9: inputs flipped mid-frame must not reach the stream
  task automatic t_capture();
    clear_cfg();
    for (int k = 0; k < 7; k++) set_slot(k, 3'(k + 1), 4'd3, 1'b0);
    run_frame("R9", 3, -1);
    load_samples();
  endtask

  // R11: quiet lines after a frame
  task automatic t_idle();
    clear_cfg();
    set_slot(0, 3'd1, 4'd1, 1'b1);
    run_frame("R11", -1, -1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11", "idle sdata", 32'(sdata), 32'd0);
      chk("R11", "idle busy", 32'(busy), 32'd0);
    end
  endtask

  // R10: strobe during a frame is ignored and flagged until reset
  task automatic t_overrun();
    clear_cfg();
    chk("R10", "overrun before", 32'(overrun), 32'd0);
    set_slot(0, 3'd2, 4'd4, 1'b1);
    set_slot(1, 3'd3, 4'd4, 1'b1);
    run_frame("R10", -1, 4);
    chk("R10", "overrun set", 32'(overrun), 32'd1);
    repeat (5) @(negedge clk);
    chk("R10", "overrun held", 32'(overrun), 32'd1);
    do_reset();
    chk("R10", "overrun cleared by reset", 32'(overrun), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog (R11) actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_cfg();
    load_samples();
    do_reset();
    t_reset();
    t_widths();
    t_sources();
    t_wide();
    t_disabled();
    t_delay();
    t_sync_pos();
    t_polarity();
    t_mask();
    t_capture();
    t_idle();
    t_overrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule